// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer whose write side and read side may run on separate clocks. Write and read pointers cross between the two domains as Gray codes through two-flop synchronizers; the write side produces a registered full flag and the read side a registered empty flag. Reads use standard timing: a word appears on the data output on the read-clock edge that accepts the read request.

On top of normal operation the buffer can replay what it holds. A replay request is sampled on a read-clock edge. If the number of words written since the last reset is legal, that edge rewinds the read pointer to memory location zero and forces the empty flag high. Normal reads that follow return the stored words again from the first one written after reset. A request outside the legal fill window changes nothing and raises a one-cycle error pulse.

Two resets are provided, both synchronous and active low. The master reset clears the pointers, the flags and the output register. The partial reset clears the pointers and flags but leaves the last word on the data output.

Top module: `fifo_rt`

## Requirements
- R1: While or after master reset, `empty` is 1, `full` is 0, `rt_err` is 0 and `dout` is all zeros.
- R2: Words are read in the order they were written; `dout` takes the new word on the read-clock edge where `ren` is 1, `rt_n` is 1 and `empty` is 0.
- R3: `full` is 1 right after the write edge that stores the DEPTH-th unread word; a write while `full` is 1 stores nothing and leaves the write pointer unchanged.
- R4: A read while `empty` is 1 is ignored: `dout` keeps its value.
- R5: When `rt_n` is 0 at a read-clock edge and between 1 and DEPTH-2 words (inclusive) have been written since the last reset, that edge rewinds the read pointer to location zero, sets `empty` to 1 and ignores `ren` (`dout` unchanged).
- R6: After a rewind, `empty` clears on the next read-clock edge when data is stored, and reads return the words again starting with the first word written after the last reset.
- R7: When `rt_n` is 0 at a read-clock edge and either no words or more than DEPTH-2 words have been written since the last reset, the read pointer does not move, `ren` is ignored, and `rt_err` is 1 for exactly one read-clock cycle.
- R8: A partial reset sets `empty` to 1 and `full` to 0 and restarts both pointers at location zero, while `dout` keeps its last value.
- R9: After a write into an empty buffer, `empty` stays 1 through the next two read-clock edges and clears after the third (wait through the two synchronizer stages plus the flag register), when both clocks share one source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, synchronous in each domain, active low |
| prst_n | input | 1 | Partial reset, synchronous in each domain, active low; keeps `dout` |
| wen | input | 1 | Write request, sampled on `wclk` |
| din | input | DATA_W | Write data |
| ren | input | 1 | Read request, sampled on `rclk` |
| rt_n | input | 1 | Replay request, active low, sampled on `rclk` |
| dout | output | DATA_W | Registered read data |
| empty | output | 1 | No unread word visible to the read side |
| full | output | 1 | DEPTH unread words as seen by the write side |
| rt_err | output | 1 | One-cycle pulse for a rejected replay request |

## Verification
The assertions take for granted that `wen` and `din` change only away from `wclk` edges and `ren` and `rt_n` only away from `rclk` edges, and that each reset is held low over at least one edge of each clock. The bench drives every input on the falling edge of a single clock that feeds both sides, so each sampled value is settled. Before any replay request it waits four edges after the last write so that the synchronized write pointer and the overfill marker have reached the read side, which keeps the legality decision tied to the count actually written.

// File: rtl/fifo_rt_pkg.sv
// Package: shared types and Gray-code helpers for the replay FIFO.
// Assumes pointer widths of at most 32 bits; callers size the results.
package fifo_rt_pkg;

    // Read-side action chosen for one rclk edge
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_POP    = 2'd1,
        RD_REWIND = 2'd2,
        RD_REJECT = 2'd3
    } rd_act_e;

    // Binary to reflected Gray code
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_rt_sync.sv
// Module: two-flop synchronizer for a bus of W bits.
// Assumes multi-bit inputs change at most one bit per source edge
// (Gray code) or are monotonic single bits.
module fifo_rt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo_rt_mem.sv
// Module: storage array, written on wclk, read combinationally.
// Assumes the read controller registers the output word.
module fifo_rt_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per accepted write
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_rt_wr.sv
// Module: write-side controller. Keeps the binary and Gray write
// pointers, the registered full flag and a sticky marker that is set
// once more than DEPTH-2 words have been accepted since reset.
// Assumes rgray_s is the read Gray pointer already synchronized to wclk.
module fifo_rt_wr #(
    parameter int ADDR_W = 4
) (
    input  logic            wclk,
    input  logic            rst_n,
    input  logic            wen,
    input  logic [ADDR_W:0] rgray_s,
    output logic            wr_fire,
    output logic [ADDR_W:0] wbin,
    output logic [ADDR_W:0] wgray,
    output logic            full,
    output logic            over
);
    import fifo_rt_pkg::*;

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] OVER_MARK = PW'(DEPTH - 1);

    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] wgray_nx;
    logic [PW-1:0] rgray_full;

    // Next write pointer in binary and Gray form
    always_comb begin
        wr_fire    = wen && !full;
        wbin_nx    = wbin + PW'(wr_fire);
        wgray_nx   = PW'(to_gray(32'(wbin_nx)));
        rgray_full = {~rgray_s[ADDR_W:ADDR_W-1], rgray_s[ADDR_W-2:0]};
    end

    // Pointer, full flag and overfill marker registers
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            over  <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            full  <= (wgray_nx == rgray_full);
            if (wr_fire && (wbin_nx == OVER_MARK)) begin
                over <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fifo_rt_rd.sv
// Module: read-side controller. Chooses between pop, rewind, reject
// and idle each rclk edge, keeps the read pointers, the registered
// empty flag, the output word and the reject pulse.
// Assumes wgray_s and over_s are already synchronized to rclk.
module fifo_rt_rd #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              ren,
    input  logic              rt_n,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic              over_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic              empty,
    output logic [DATA_W-1:0] dout,
    output logic              rt_err
);
    import fifo_rt_pkg::*;

    localparam int PW = ADDR_W + 1;

    rd_act_e       act;
    logic [PW-1:0] wbin_s;
    logic          rt_legal;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] rgray_nx;

    // Decide the action for this edge; replay requests override reads
    always_comb begin
        wbin_s   = PW'(from_gray(32'(wgray_s)));
        rt_legal = (wbin_s != '0) && !over_s;
        if (!rt_n) begin
            act = rt_legal ? RD_REWIND : RD_REJECT;
        end else if (ren && !empty) begin
            act = RD_POP;
        end else begin
            act = RD_IDLE;
        end
    end

    // Next read pointer for the chosen action
    always_comb begin
        case (act)
            RD_REWIND: rbin_nx = '0;
            RD_POP:    rbin_nx = rbin + PW'(1);
            default:   rbin_nx = rbin;
        endcase
        rgray_nx = PW'(to_gray(32'(rbin_nx)));
    end

    // Pointer, empty flag and reject pulse registers
    always_ff @(posedge rclk) begin
        if (!mrst_n || !prst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            empty  <= 1'b1;
            rt_err <= 1'b0;
        end else begin
            rbin   <= rbin_nx;
            rgray  <= rgray_nx;
            empty  <= (act == RD_REWIND) ? 1'b1 : (rgray_nx == wgray_s);
            rt_err <= (act == RD_REJECT);
        end
    end

    // Output word: cleared by master reset only, loaded on a pop
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            dout <= '0;
        end else if (prst_n && (act == RD_POP)) begin
            dout <= rdata;
        end
    end
endmodule

// File: rtl/fifo_rt.sv
// Module: dual-clock FIFO with replay from location zero.
// Assumes each reset is held low across at least one edge of both
// clocks, and each input is synchronous to its own clock.
module fifo_rt #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    input  logic              rt_n,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              rt_err
);
    localparam int PW = ADDR_W + 1;

    logic          rst_all_n;
    logic          wr_fire;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_s;
    logic          over;
    logic          over_s;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rgray;
    logic [PW-1:0] rgray_s;
    logic [DATA_W-1:0] rdata;

    assign rst_all_n = mrst_n && prst_n;

    fifo_rt_wr #(.ADDR_W(ADDR_W)) u_wr (
        .wclk    (wclk),
        .rst_n   (rst_all_n),
        .wen     (wen),
        .rgray_s (rgray_s),
        .wr_fire (wr_fire),
        .wbin    (wbin),
        .wgray   (wgray),
        .full    (full),
        .over    (over)
    );

    fifo_rt_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wclk),
        .we    (wr_fire),
        .waddr (wbin[ADDR_W-1:0]),
        .wdata (din),
        .raddr (rbin[ADDR_W-1:0]),
        .rdata (rdata)
    );

    fifo_rt_sync #(.W(PW)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rst_all_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    fifo_rt_sync #(.W(1)) u_sync_over (
        .clk   (rclk),
        .rst_n (rst_all_n),
        .d     (over),
        .q     (over_s)
    );

    fifo_rt_sync #(.W(PW)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (rst_all_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    fifo_rt_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk    (rclk),
        .mrst_n  (mrst_n),
        .prst_n  (prst_n),
        .ren     (ren),
        .rt_n    (rt_n),
        .wgray_s (wgray_s),
        .over_s  (over_s),
        .rdata   (rdata),
        .rbin    (rbin),
        .rgray   (rgray),
        .empty   (empty),
        .dout    (dout),
        .rt_err  (rt_err)
    );
endmodule

// File: rtl/fifo_rt_chk.sv
// Module: property checker for fifo_rt, attached by bind below.
// Assumes inputs are stable around the edges of their own clock.
module fifo_rt_chk #(
    parameter int DATA_W = 8,
    parameter int PW     = 5
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              wen,
    input logic              ren,
    input logic              rt_n,
    input logic              empty,
    input logic              full,
    input logic              rt_err,
    input logic [DATA_W-1:0] dout,
    input logic [PW-1:0]     wbin,
    input logic [PW-1:0]     rbin
);
    // R2
    pop_advance_chk: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (!empty && ren && rt_n) |=> (rbin == PW'($past(rbin) + PW'(1))));

    // R3
    full_write_block_chk: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        (full && wen) |=> $stable(wbin));

    // R4
    empty_read_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (empty && ren) |=> $stable(dout));

    // R5
    rewind_or_reject_chk: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (!rt_n) |=> (rt_err || (empty && (rbin == '0))));

    // R7
    reject_holds_ptr_chk: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        rt_err |-> $stable(rbin));
endmodule

bind fifo_rt fifo_rt_chk #(.DATA_W(DATA_W), .PW(PW)) u_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .mrst_n (mrst_n),
    .prst_n (prst_n),
    .wen    (wen),
    .ren    (ren),
    .rt_n   (rt_n),
    .empty  (empty),
    .full   (full),
    .rt_err (rt_err),
    .dout   (dout),
    .wbin   (wbin),
    .rbin   (rbin)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    // Op codes: 0 write, 1 read, 2 replay, 3 read while empty
    localparam int NVEC = 10;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 8'h11, 8'h00},
        {2'd0, 8'h22, 8'h00},
        {2'd0, 8'h33, 8'h00},
        {2'd1, 8'h00, 8'h11},
        {2'd1, 8'h00, 8'h22},
        {2'd2, 8'h00, 8'h22},
        {2'd1, 8'h00, 8'h11},
        {2'd1, 8'h00, 8'h22},
        {2'd1, 8'h00, 8'h33},
        {2'd3, 8'h00, 8'h33}
    };

    logic clk = 1'b0;
    logic mrst_n = 1'b0;
    logic prst_n = 1'b1;
    logic wen = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic ren = 1'b0;
    logic rt_n = 1'b1;
    logic [DATA_W-1:0] dout;
    logic empty, full, rt_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_rt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .wclk (clk), .rclk (clk), .mrst_n (mrst_n), .prst_n (prst_n),
        .wen (wen), .din (din), .ren (ren), .rt_n (rt_n),
        .dout (dout), .empty (empty), .full (full), .rt_err (rt_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [DATA_W-1:0] d);
        wen = 1'b1; din = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic pop();
        ren = 1'b1;
        @(negedge clk);
        ren = 1'b0;
    endtask

    task automatic replay();
        rt_n = 1'b0; ren = 1'b1;
        @(negedge clk);
        rt_n = 1'b1; ren = 1'b0;
    endtask

    task automatic mreset();
        mrst_n = 1'b0;
        idle(2);
        mrst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        mreset();
        // R1: reset state
        check(empty == 1'b1, "R1 empty", int'(empty), 1);
        check(full == 1'b0, "R1 full", int'(full), 0);
        check(rt_err == 1'b0, "R1 rt_err", int'(rt_err), 0);
        check(dout == '0, "R1 dout", int'(dout), 0);

        // Table walk: order, replay, replayed reads, empty read
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] dv, ev;
            op = VEC[i][17:16]; dv = VEC[i][15:8]; ev = VEC[i][7:0];
            case (op)
                2'd0: push(dv);
                2'd1: begin
                    pop();
                    check(dout == ev, (i > 5) ? "R6 replayed read" : "R2 read order", int'(dout), int'(ev));
                end
                2'd2: begin
                    replay();
                    check(empty == 1'b1, "R5 empty on rewind", int'(empty), 1);
                    check(dout == ev, "R5 read ignored on rewind", int'(dout), int'(ev));
                    check(rt_err == 1'b0, "R5 no error", int'(rt_err), 0);
                    idle(1);
                    check(empty == 1'b0, "R6 empty clears", int'(empty), 0);
                end
                default: begin
                    pop();
                    check(dout == ev, "R4 empty read hold", int'(dout), int'(ev));
                    check(empty == 1'b1, "R4 still empty", int'(empty), 1);
                end
            endcase
            idle(4);
        end

        // R9: empty latency through synchronizers
        mreset();
        push(8'hA5);
        idle(1);
        check(empty == 1'b1, "R9 after edge 1", int'(empty), 1);
        idle(1);
        check(empty == 1'b1, "R9 after edge 2", int'(empty), 1);
        idle(1);
        check(empty == 1'b0, "R9 after edge 3", int'(empty), 0);

        // R7: replay with zero words written
        mreset();
        replay();
        check(rt_err == 1'b1, "R7 zero words", int'(rt_err), 1);
        idle(1);
        check(rt_err == 1'b0, "R7 single pulse", int'(rt_err), 0);

        // R3: fill to DEPTH, blocked write, then over-limit replay
        mreset();
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(8'h40 + i));
            if (i == DEPTH - 2) check(full == 1'b0, "R3 not full", int'(full), 0);
        end
        check(full == 1'b1, "R3 full", int'(full), 1);
        push(8'hEE);
        idle(4);
        for (int i = 0; i < 3; i++) pop();
        check(dout == 8'h42, "R2 third read", int'(dout), 8'h42);
        replay();
        check(rt_err == 1'b1, "R7 over limit", int'(rt_err), 1);
        idle(4);
        for (int i = 3; i < DEPTH; i++) begin
            pop();
            check(dout == 8'(8'h40 + i), "R7 pointer kept", int'(dout), 8'h40 + i);
        end
        check(empty == 1'b1, "R3 empty after DEPTH reads", int'(empty), 1);
        pop();
        check(dout == 8'h4F, "R3 blocked write not stored", int'(dout), 8'h4F);

        // R5: largest legal fill, DEPTH-2 words
        mreset();
        for (int i = 0; i < DEPTH - 2; i++) push(8'(8'h60 + i));
        idle(4);
        pop();
        pop();
        replay();
        check(rt_err == 1'b0, "R5 DEPTH-2 accepted", int'(rt_err), 0);
        check(dout == 8'h61, "R5 read ignored", int'(dout), 8'h61);
        idle(4);
        pop();
        check(dout == 8'h60, "R6 first word again", int'(dout), 8'h60);

        // R8: partial reset keeps dout
        prst_n = 1'b0;
        idle(1);
        prst_n = 1'b1;
        idle(1);
        check(empty == 1'b1, "R8 empty", int'(empty), 1);
        check(full == 1'b0, "R8 full", int'(full), 0);
        check(dout == 8'h60, "R8 dout kept", int'(dout), 8'h60);
        push(8'h99);
        idle(4);
        pop();
        check(dout == 8'h99, "R8 restart at zero", int'(dout), 8'h99);
        replay();
        idle(4);
        pop();
        check(dout == 8'h99, "R6 replay after partial reset", int'(dout), 8'h99);

        // R1: master reset clears dout
        mreset();
        check(dout == '0, "R1 dout cleared", int'(dout), 0);
        check(empty == 1'b1, "R1 empty again", int'(empty), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule